// File: doc/BRIEF.md
# Divided Clock Phase Selector

This block turns a fast source clock into two card-interface clocks. It divides the source by four. From the divided clock it produces eight copies, spaced at 45-degree steps, and all eight are built from flip-flops. A drive clock and a sample clock each pick one of the eight copies on their own. The drive clock launches command and data toward a card, and its phase is moved to meet the card's hold time. The sample clock captures what the card returns. The sample clock can also bypass the phase copies and pass an alternate clock input through.

The selections come in as static configuration inputs. When a selection changes, the affected output goes quiet and resumes only on a rising edge of the newly chosen copy, so it never emits a shortened pulse. After reset both outputs stay low through the first whole divided period.

A step, in what follows, is half a period of the source clock. Step 0 begins at the first rising source edge after reset is released. One divided period is therefore 8 steps.

Top module: `phase_sel_top`

## Requirements
- R1: The counter advances once per rising source edge. Every output driven from a phase copy, once settled, repeats every 8 steps (4 source cycles) and is high for exactly 4 consecutive steps in each period.
- R2: With drive code n on `drvPhase` (3 bits, shift of n×45 degrees, code 0 aligned with the unshifted divided clock), `drvClk` is high at exactly those steps s where (s − n) mod 8 is 0, 1, 2 or 3.
- R3: With `smpUseAlt` = 0, sample code m on `smpPhase` follows the same mapping on `smpClk`, independently of the drive code. The drive output is unaffected by the sample code, by `smpUseAlt` and by `altSmpClk`.
- R4: When `smpUseAlt` = 1, `smpClk` equals `altSmpClk` once settled. When it is 0, the phase copy is used.
- R5: After any change of a code or of the source select, the affected output stays low until a rising edge of the newly selected source. Every pulse from a phase copy lasts exactly 4 steps (no runt). Rising edges occur only at steps aligned with the old code (before the switch takes effect) or with the new code.
- R6: `rst` is synchronous and active high. Both outputs are low from the first rising edge with `rst` high, and they stay low through steps 0 to 7 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkSrc | input | 1 | Source clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| drvPhase | input | PHASE_W (3) | Drive clock phase code, n×45 degrees |
| smpPhase | input | PHASE_W (3) | Sample clock phase code, n×45 degrees |
| smpUseAlt | input | 1 | 0: sample clock from phase copy, 1: from `altSmpClk` |
| altSmpClk | input | 1 | Alternate sample clock |
| drvClk | output | 1 | Drive clock toward the card |
| smpClk | output | 1 | Sample clock for returning data |

## Verification
The bench uses the default PHASE_W of 3, which gives a divide-by-four and eight phase copies. With that setting, every code on both selectors can be swept in one run, with the two outputs always set to different phases. The same width keeps a full divided period down to eight half-steps, so the bench can follow each step. A bench-side step model predicts every half-cycle. Rapid back-to-back code changes and moves to and from the alternate input then show whether any pulse is cut short or placed on a wrong step. A reset in the middle of a run checks that both outputs stay low for a whole period after release.

// File: rtl/phase_sel_pkg.sv
package phase_sel_pkg;

  localparam int CH_DRV = 0;
  localparam int CH_SMP = 1;
  localparam int NUM_CH = 2;

  // Per-channel commands from the control to the datapath
  typedef struct packed {
    logic gateOn;   // open the output gate at this edge
    logic gateOff;  // close the output gate at this edge
    logic selLoad;  // take the configured selection into the live selection
  } chStrobe_t;

endpackage

// File: rtl/phase_sel_datapath.sv
module phase_sel_datapath
  import phase_sel_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic                               clkSrc,
  input  logic                               rst,
  input  logic                               altClkIn,
  input  logic [NUM_CH-1:0][PHASE_W-1:0]     cfgSel,
  input  logic                               smpAltCfg,
  input  chStrobe_t [NUM_CH-1:0]             strb,
  output logic [PHASE_W-2:0]                 cntQ,
  output logic [NUM_CH-1:0][PHASE_W-1:0]     curSelQ,
  output logic                               smpAltQ,
  output logic [NUM_CH-1:0]                  gateQ,
  output logic [NUM_CH-1:0]                  chClk
);

  localparam int NUM_TAPS = 1 << PHASE_W;
  localparam int DIV      = NUM_TAPS / 2;
  localparam int CNT_W    = PHASE_W - 1;

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    cntNext;
  logic [DIV-1:0]      evenTap;
  logic [DIV-1:0]      oddTap;
  logic [NUM_TAPS-1:0] tapBus;

  assign cntNext = cnt + CNT_W'(1);
  assign cntQ    = cnt;

  // Divider: one count per rising source edge, DIV counts per divided period
  always_ff @(posedge clkSrc) begin
    if (rst) cnt <= CNT_W'(DIV - 1);
    else     cnt <= cntNext;
  end

  // Even taps (0, 90, 180, 270 degrees for the default width): registered on the rising edge
  for (genvar k = 0; k < DIV; k++) begin : g_even
    logic [CNT_W-1:0] diff;
    assign diff = cntNext - CNT_W'(k);
    always_ff @(posedge clkSrc) begin
      if (rst) evenTap[k] <= 1'b0;
      else     evenTap[k] <= ~diff[CNT_W-1];
    end
  end

  // Odd taps: half a source period later, copied on the falling edge
  always_ff @(negedge clkSrc) begin
    if (rst) oddTap <= '0;
    else     oddTap <= evenTap;
  end

  for (genvar k = 0; k < DIV; k++) begin : g_bus
    assign tapBus[2*k]   = evenTap[k];
    assign tapBus[2*k+1] = oddTap[k];
  end

  // Per-channel live selection, gate and output
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PHASE_W-1:0] selR;
    logic               gateR;

    always_ff @(posedge clkSrc) begin
      if (rst) begin
        selR  <= '0;
        gateR <= 1'b0;
      end else begin
        if (strb[c].selLoad) selR <= cfgSel[c];
        if (strb[c].gateOff)     gateR <= 1'b0;
        else if (strb[c].gateOn) gateR <= 1'b1;
      end
    end

    assign curSelQ[c] = selR;
    assign gateQ[c]   = gateR;

    if (c == CH_SMP) begin : g_smp
      logic altR;
      always_ff @(posedge clkSrc) begin
        if (rst)                  altR <= 1'b0;
        else if (strb[c].selLoad) altR <= smpAltCfg;
      end
      assign smpAltQ  = altR;
      assign chClk[c] = gateR & (altR ? altClkIn : tapBus[selR]);
    end else begin : g_drv
      assign chClk[c] = gateR & tapBus[selR];
    end
  end

endmodule

// File: rtl/phase_sel_control.sv
module phase_sel_control
  import phase_sel_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic                           clkSrc,
  input  logic                           rst,
  input  logic [PHASE_W-2:0]             cntQ,
  input  logic [NUM_CH-1:0][PHASE_W-1:0] cfgSel,
  input  logic                           smpAltCfg,
  input  logic [NUM_CH-1:0][PHASE_W-1:0] curSelQ,
  input  logic                           smpAltQ,
  input  logic [NUM_CH-1:0]              gateQ,
  input  logic                           altClkIn,
  output chStrobe_t [NUM_CH-1:0]         strb
);

  localparam int NUM_TAPS = 1 << PHASE_W;
  localparam int DIV      = NUM_TAPS / 2;
  localparam int CNT_W    = PHASE_W - 1;

  logic [CNT_W-1:0] cntNext;
  logic             warm;

  assign cntNext = cntQ + CNT_W'(1);

  // A tap is quiet at a rising edge when it is low on both sides of that edge
  function automatic logic tapQuiet(input logic [CNT_W-1:0] cn, input logic [PHASE_W-1:0] sel);
    logic [PHASE_W-1:0] sNew;
    logic [PHASE_W-1:0] sPrev;
    logic [PHASE_W-1:0] dNew;
    logic [PHASE_W-1:0] dPrev;
    sNew  = {cn, 1'b0};
    sPrev = sNew - PHASE_W'(1);
    dNew  = sNew - sel;
    dPrev = sPrev - sel;
    return dNew[PHASE_W-1] & dPrev[PHASE_W-1];
  endfunction

  // No gate opens before the first divided period after reset has run out
  always_ff @(posedge clkSrc) begin
    if (rst)                               warm <= 1'b0;
    else if (cntNext == CNT_W'(DIV - 1))   warm <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic      pending;
    logic      quiet;
    chStrobe_t cmd;

    if (c == CH_SMP) begin : g_smp
      assign pending = (cfgSel[c] != curSelQ[c]) | (smpAltCfg != smpAltQ);
      assign quiet   = smpAltQ ? ~altClkIn : tapQuiet(cntNext, curSelQ[c]);
    end else begin : g_drv
      assign pending = (cfgSel[c] != curSelQ[c]);
      assign quiet   = tapQuiet(cntNext, curSelQ[c]);
    end

    always_comb begin
      cmd = '0;
      if (gateQ[c]) begin
        if (pending && quiet) begin
          cmd.gateOff = 1'b1;
          cmd.selLoad = 1'b1;
        end
      end else begin
        if (pending)             cmd.selLoad = 1'b1;
        else if (warm && quiet)  cmd.gateOn  = 1'b1;
      end
    end

    assign strb[c] = cmd;
  end

endmodule

// File: rtl/phase_sel_top.sv
module phase_sel_top
  import phase_sel_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clkSrc,
  input  logic               rst,
  input  logic [PHASE_W-1:0] drvPhase,
  input  logic [PHASE_W-1:0] smpPhase,
  input  logic               smpUseAlt,
  input  logic               altSmpClk,
  output logic               drvClk,
  output logic               smpClk
);

  logic [NUM_CH-1:0][PHASE_W-1:0] cfgSel;
  logic [NUM_CH-1:0][PHASE_W-1:0] curSelQ;
  logic [PHASE_W-2:0]             cntQ;
  logic                           smpAltQ;
  logic [NUM_CH-1:0]              gateQ;
  logic [NUM_CH-1:0]              chClk;
  chStrobe_t [NUM_CH-1:0]         strb;

  assign cfgSel[CH_DRV] = drvPhase;
  assign cfgSel[CH_SMP] = smpPhase;

  phase_sel_datapath #(.PHASE_W(PHASE_W)) u_dp (
    .clkSrc    (clkSrc),
    .rst       (rst),
    .altClkIn  (altSmpClk),
    .cfgSel    (cfgSel),
    .smpAltCfg (smpUseAlt),
    .strb      (strb),
    .cntQ      (cntQ),
    .curSelQ   (curSelQ),
    .smpAltQ   (smpAltQ),
    .gateQ     (gateQ),
    .chClk     (chClk)
  );

  phase_sel_control #(.PHASE_W(PHASE_W)) u_ctl (
    .clkSrc    (clkSrc),
    .rst       (rst),
    .cntQ      (cntQ),
    .cfgSel    (cfgSel),
    .smpAltCfg (smpUseAlt),
    .curSelQ   (curSelQ),
    .smpAltQ   (smpAltQ),
    .gateQ     (gateQ),
    .altClkIn  (altSmpClk),
    .strb      (strb)
  );

  assign drvClk = chClk[CH_DRV];
  assign smpClk = chClk[CH_SMP];

endmodule

// File: rtl/phase_sel_chk.sv
module phase_sel_chk
  import phase_sel_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input logic                           clkSrc,
  input logic                           rst,
  input logic [PHASE_W-2:0]             cntQ,
  input chStrobe_t [NUM_CH-1:0]         strb,
  input logic [NUM_CH-1:0]              gateQ,
  input logic [NUM_CH-1:0][PHASE_W-1:0] curSelQ,
  input logic                           smpAltQ,
  input logic                           drvClk,
  input logic                           smpClk
);

  localparam int CNT_W = PHASE_W - 1;

  // Step of the half-period just before a rising edge, and the level each channel should show there
  logic [PHASE_W-1:0] sOdd;
  logic [PHASE_W-1:0] dDrv;
  logic [PHASE_W-1:0] dSmp;
  logic               expDrv;
  logic               expSmp;

  always_comb begin
    sOdd   = {cntQ, 1'b1};
    dDrv   = sOdd - curSelQ[CH_DRV];
    dSmp   = sOdd - curSelQ[CH_SMP];
    expDrv = ~dDrv[PHASE_W-1];
    expSmp = ~dSmp[PHASE_W-1];
  end

  AST_RESET_DARK: assert property (@(posedge clkSrc) rst |=> (!drvClk && !smpClk)); // R6
  AST_CNT_ADVANCE: assert property (@(posedge clkSrc) disable iff (rst) !$past(rst) |-> (cntQ == CNT_W'($past(cntQ) + 1'b1))); // R1
  AST_DRV_PHASE: assert property (@(posedge clkSrc) disable iff (rst) gateQ[CH_DRV] |-> (drvClk == expDrv)); // R2
  AST_SMP_PHASE: assert property (@(posedge clkSrc) disable iff (rst) (gateQ[CH_SMP] && !smpAltQ) |-> (smpClk == expSmp)); // R3
  AST_DRV_STRB_EXCL: assert property (@(posedge clkSrc) disable iff (rst) $onehot0({strb[CH_DRV].gateOn, strb[CH_DRV].gateOff})); // R5
  AST_SMP_STRB_EXCL: assert property (@(posedge clkSrc) disable iff (rst) $onehot0({strb[CH_SMP].gateOn, strb[CH_SMP].gateOff})); // R5
  AST_DRV_CLOSE_LOW: assert property (@(posedge clkSrc) disable iff (rst) strb[CH_DRV].gateOff |-> !drvClk); // R5
  AST_SMP_CLOSE_LOW: assert property (@(posedge clkSrc) disable iff (rst) strb[CH_SMP].gateOff |-> !smpClk); // R5
  AST_DRV_LOAD_SHUT: assert property (@(posedge clkSrc) disable iff (rst) strb[CH_DRV].selLoad |-> (!gateQ[CH_DRV] || strb[CH_DRV].gateOff)); // R5
  AST_SMP_LOAD_SHUT: assert property (@(posedge clkSrc) disable iff (rst) strb[CH_SMP].selLoad |-> (!gateQ[CH_SMP] || strb[CH_SMP].gateOff)); // R5

endmodule

bind phase_sel_top phase_sel_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clkSrc  (clkSrc),
  .rst     (rst),
  .cntQ    (cntQ),
  .strb    (strb),
  .gateQ   (gateQ),
  .curSelQ (curSelQ),
  .smpAltQ (smpAltQ),
  .drvClk  (drvClk),
  .smpClk  (smpClk)
);

// File: tb/phase_sel_top_tb.sv
`timescale 1ns/1ps
module phase_sel_top_tb;

  logic       clkSrc = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] drvPhase = 3'd0;
  logic [2:0] smpPhase = 3'd0;
  logic       smpUseAlt = 1'b0;
  logic       altSmpClk = 1'b0;
  logic       drvClk;
  logic       smpClk;

  int nChecks = 0;
  int nFails = 0;
  int stepIdx = 0;
  int drvCode = 0, drvOld = 0, smpCode = 0, smpOld = 0;
  bit smpAlt = 0, smpAltOld = 0;
  bit drvPrev = 0, smpPrev = 0;
  int drvLen = 0, smpLen = 0;
  bit smpPulseAlt = 0;
  bit done = 0;

  phase_sel_top u_dut (
    .clkSrc    (clkSrc),
    .rst       (rst),
    .drvPhase  (drvPhase),
    .smpPhase  (smpPhase),
    .smpUseAlt (smpUseAlt),
    .altSmpClk (altSmpClk),
    .drvClk    (drvClk),
    .smpClk    (smpClk)
  );

  always #2 clkSrc = ~clkSrc;

  initial begin
    #0.5;
    forever #5 altSmpClk = ~altSmpClk;
  end

  function automatic int mod8(int x);
    return ((x % 8) + 8) % 8;
  endfunction

  function automatic bit tapModel(int s, int n);
    return mod8(s - n) < 4;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (step %0d)", req, act, exp, stepIdx);
    end
  endtask

  // Advance one half source period, sample mid-step, watch pulse shape and placement (R5, R1)
  task automatic step();
    @(clkSrc);
    #1;
    stepIdx++;
    if (rst) begin
      drvLen = 0; smpLen = 0; drvPrev = drvClk; smpPrev = smpClk;
      return;
    end
    if (drvClk && !drvPrev) begin
      check(mod8(stepIdx - drvCode) == 0 || mod8(stepIdx - drvOld) == 0,
            "R5 drive rise placement", mod8(stepIdx), drvCode);
      if (mod8(stepIdx - drvCode) == 0) drvOld = drvCode;
      drvLen = 1;
    end else if (drvClk) begin
      drvLen++;
    end else if (drvPrev && drvLen > 0) begin
      check(drvLen == 4, "R5 drive pulse width", drvLen, 4);
      drvLen = 0;
    end
    if (smpClk && !smpPrev) begin
      smpPulseAlt = smpAlt || smpAltOld;
      if (!smpPulseAlt) begin
        check(mod8(stepIdx - smpCode) == 0 || mod8(stepIdx - smpOld) == 0,
              "R5 sample rise placement", mod8(stepIdx), smpCode);
        if (mod8(stepIdx - smpCode) == 0) smpOld = smpCode;
      end
      smpLen = 1;
    end else if (smpClk) begin
      smpLen++;
    end else if (smpPrev && smpLen > 0) begin
      if (!smpPulseAlt) check(smpLen == 4, "R5 sample pulse width", smpLen, 4);
      smpLen = 0;
    end
    drvPrev = drvClk;
    smpPrev = smpClk;
  endtask

  task automatic setCodes(int d, int s, bit alt);
    drvOld = drvCode; drvCode = d; drvPhase = 3'(d);
    smpOld = smpCode; smpCode = s; smpPhase = 3'(s);
    smpAltOld = smpAlt; smpAlt = alt; smpUseAlt = alt;
  endtask

  task automatic settle(int n);
    repeat (n) step();
    drvOld = drvCode; smpOld = smpCode; smpAltOld = smpAlt;
  endtask

  // Compare every step against the step model (R2, R3, R4) and count shape (R1)
  task automatic track(int n);
    int drvHigh = 0, drvRise = 0;
    bit last = drvClk;
    for (int i = 0; i < n; i++) begin
      step();
      check(drvClk == tapModel(stepIdx, drvCode), "R2 drive level", drvClk, tapModel(stepIdx, drvCode));
      if (smpAlt)
        check(smpClk == altSmpClk, "R4 sample follows alternate", smpClk, altSmpClk);
      else
        check(smpClk == tapModel(stepIdx, smpCode), "R3 sample level", smpClk, tapModel(stepIdx, smpCode));
      if (drvClk) drvHigh++;
      if (drvClk && !last) drvRise++;
      last = drvClk;
    end
    check(drvHigh == n / 2, "R1 drive duty", drvHigh, n / 2);
    check(drvRise == n / 8, "R1 drive period", drvRise, n / 8);
  endtask

  // Reset with outputs dark, release in the low half so the next edge is step 0 (R6)
  task automatic t_reset();
    @(negedge clkSrc);
    #1;
    rst = 1'b1;
    repeat (4) begin
      @(clkSrc);
      #1;
      check(!drvClk && !smpClk, "R6 low during reset", {drvClk, smpClk}, 0);
    end
    rst = 1'b0;
    stepIdx = -1;
    drvLen = 0; smpLen = 0; drvPrev = drvClk; smpPrev = smpClk;
    for (int i = 0; i < 8; i++) begin
      step();
      check(!drvClk && !smpClk, "R6 low through first period", {drvClk, smpClk}, 0);
    end
  endtask

  task automatic t_steady_sweep();
    for (int k = 0; k < 8; k++) begin
      setCodes(k, (k + 3) % 8, 1'b0);
      settle(32);
      track(16);
    end
  endtask

  task automatic t_rapid_switch();
    setCodes(2, 5, 1'b0);
    repeat (5) step();
    setCodes(6, 1, 1'b0);
    repeat (3) step();
    setCodes(1, 6, 1'b0);
    settle(32);
    track(16);
    setCodes(7, 0, 1'b0);
    repeat (1) step();
    setCodes(0, 7, 1'b0);
    settle(32);
    track(16);
  endtask

  task automatic t_alternate();
    setCodes(4, 2, 1'b1);
    settle(40);
    track(24);
    setCodes(5, 2, 1'b1);
    settle(32);
    track(24);
    setCodes(5, 6, 1'b0);
    settle(40);
    track(16);
  endtask

  task automatic t_reset_mid();
    setCodes(5, 0, 1'b0);
    t_reset();
    settle(24);
    track(16);
  endtask

  initial begin
    drvPhase = 3'd3; smpPhase = 3'd6; drvCode = 3; smpCode = 6; drvOld = 3; smpOld = 6;
    t_reset();
    settle(24);
    track(16);
    t_steady_sweep();
    t_rapid_switch();
    t_alternate();
    t_reset_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule